// File: doc/BRIEF.md
# Serial ID Readback Realigner

This block fetches the identification bytes of a display controller over a 9-bit serial link and decides whether they match a known value. On a start request it drops chip select, shifts out one 9-bit command word (a leading flag bit of 0 followed by the get-ID opcode), then keeps clocking for one 9-bit receive word per requested byte. The controller inserts one dummy clock before its reply. Because of that, every received word sits one bit further off its byte boundary than the word before it. The block undoes this drift by splicing bits carried over from the preceding word into each word, and it presents the true bytes.

The recovered bytes are compared with the expected ID. The result is reported as a flag and a request-done indication. A mismatch is advisory only: the block never blocks or retries, so the surrounding sequencer carries on with initialization whatever the result. A board strap that marks the receive line as absent skips the exchange entirely and reports a pass. Requests for an unsupported number of bytes are refused with an error and cause no bus activity.

Top module: `id_readback_realigner`

## Requirements
- R1: After reset, sclk is low, cs_n and sdo hold 1 and 0, and done, valid, id_ok, len_err and id_bytes are all zero.
- R2: An accepted request first sends the 9-bit word {1'b0, 8'h04} MSB first. sdo only changes while sclk is low, the device samples on the rising edge, and sclk is low whenever cs_n is high.
- R3: The receive phase gives exactly 9 sclk rising edges per requested byte, so a request of N bytes produces 9*(N+1) rising edges in total. sdi is sampled on each rising edge, MSB first, into the current word.
- R4: Output byte i equals bits [7:0] of (word i >> i) OR (carry << (9 - i)). Bytes 0 and 1 always use a zero carry.
- R5: The carry used for byte i (i >= 2) is the low i-1 bits of received word i-1. For a contiguous reply stream after one dummy bit, byte i therefore equals the i-th streamed byte.
- R6: req_len must be 1, 3 or 4. Any other value sets done and len_err one cycle after start, leaves valid and id_ok at 0, and never drives cs_n low.
- R7: id_ok is 1 only if each received byte among the first three equals the expected ID 0x85, 0x85, 0x52 at its position. A single differing byte clears id_ok. A fourth byte is not compared.
- R8: With no_rx_line high at start, no transfer happens. One cycle later done and id_ok are 1 and valid and len_err are 0. The strap takes precedence over a bad length.
- R9: done, valid, id_ok, len_err and id_bytes hold their values until the next accepted start. A start pulse while a transfer is in progress is ignored.
- R10: Byte i appears on id_bytes[8*i+7:8*i]. Byte positions at or above the requested length read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to read the ID |
| req_len | input | 3 | Number of bytes to read (1, 3 or 4) |
| no_rx_line | input | 1 | Strap: receive line absent, skip the check |
| sdi | input | 1 | Serial data from the controller |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| sdo | output | 1 | Serial data to the controller |
| id_bytes | output | 32 | Realigned bytes, byte i at bits 8i+7:8i |
| done | output | 1 | Request finished (transfer, skip or error) |
| valid | output | 1 | id_bytes hold data from a completed transfer |
| id_ok | output | 1 | ID matched or check skipped |
| len_err | output | 1 | Request refused for unsupported length |

## Verification
A wrong receive bit counter or word pointer would show up as a wrong number of sclk edges. It would also misplace bits, and that damage grows with each later byte, so it becomes visible within one request as id_bytes that differ from the streamed reply. A wrong carry would corrupt only bytes 2 and 3 and would be caught as soon as a read of three or four bytes completes. The bench therefore streams known bytes behind both dummy-bit values and flips single bits in each ID position. Faults in the request decoder would show one cycle after start, as a wrong done, len_err or id_ok, or as cs_n dropping when it must not.

// File: rtl/id_rd_pkg.sv
// Package: shared constants for the serial ID readback realigner.
// Assumes a 9-bit serial word whose leading bit flags command (0) or data (1).
package id_rd_pkg;
    localparam int unsigned WORD_BITS   = 9;
    localparam int unsigned MAX_BYTES   = 4;
    localparam int unsigned ID_BYTES    = 3;
    localparam logic [7:0]  CMD_GET_ID  = 8'h04;

    // Expected controller identification byte at position i.
    function automatic logic [7:0] expected_id(input int unsigned i);
        case (i)
            0:       return 8'h85;
            1:       return 8'h85;
            default: return 8'h52;
        endcase
    endfunction
endpackage

// File: rtl/id_sclk_tick.sv
// Module: id_sclk_tick
// Produces a one-cycle tick every HALF_DIV clocks while run is high; each tick
// marks a serial clock half-period boundary. Assumes HALF_DIV >= 1.
module id_sclk_tick #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    // Count clocks within a half period; restart whenever idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || cnt_q == LAST) cnt_q <= '0;
        else                                 cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/id_serial_engine.sv
// Module: id_serial_engine
// Runs one read exchange: shifts out a 9-bit command word, then collects
// nbytes 9-bit receive words. sdo is launched while sclk is low and sdi is
// sampled on the rising edge. Assumes launch is pulsed only while idle.
module id_serial_engine #(
    parameter int unsigned MAX_BYTES = 4,
    parameter int unsigned WORD_BITS = 9,
    parameter int unsigned LEN_W     = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           launch,
    input  logic [LEN_W-1:0]               nbytes,
    input  logic [7:0]                     cmd,
    input  logic                           tick,
    input  logic                           sdi,
    output logic                           sclk,
    output logic                           cs_n,
    output logic                           sdo,
    output logic                           busy,
    output logic                           xfer_done,
    output logic [MAX_BYTES*WORD_BITS-1:0] words
);
    localparam int unsigned CNT_W = $clog2(WORD_BITS * (MAX_BYTES + 1) + 1);
    localparam int unsigned IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
    localparam int unsigned POS_W = $clog2(WORD_BITS);
    localparam logic [CNT_W-1:0] CMD_LEN  = CNT_W'(WORD_BITS);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(WORD_BITS - 1);

    logic [CNT_W-1:0]     bit_cnt_q;
    logic [CNT_W-1:0]     total_q;
    logic [WORD_BITS-1:0] tx_q;
    logic [IDX_W-1:0]     widx_q;
    logic [POS_W-1:0]     wpos_q;
    logic [WORD_BITS-1:0] word_q [MAX_BYTES];

    // Bus sequencing: chip select, serial clock phase, command shift, counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cs_n      <= 1'b1;
            sclk      <= 1'b0;
            sdo       <= 1'b0;
            xfer_done <= 1'b0;
            bit_cnt_q <= '0;
            total_q   <= '0;
            tx_q      <= '0;
        end else begin
            xfer_done <= 1'b0;
            if (launch && !busy) begin
                busy      <= 1'b1;
                cs_n      <= 1'b0;
                sclk      <= 1'b0;
                tx_q      <= {1'b0, cmd};
                sdo       <= 1'b0;
                bit_cnt_q <= '0;
                total_q   <= CMD_LEN * (CNT_W'(nbytes) + CNT_W'(1));
            end else if (busy && tick) begin
                if (!sclk) begin
                    sclk <= 1'b1;
                end else begin
                    sclk <= 1'b0;
                    if (bit_cnt_q == total_q - CNT_W'(1)) begin
                        busy      <= 1'b0;
                        cs_n      <= 1'b1;
                        sdo       <= 1'b0;
                        xfer_done <= 1'b1;
                    end else begin
                        bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                        tx_q      <= {tx_q[WORD_BITS-2:0], 1'b0};
                        sdo       <= tx_q[WORD_BITS-2];
                    end
                end
            end
        end
    end

    // Receive capture: on each rising edge past the command, shift sdi in MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n || (launch && !busy)) begin
            widx_q <= '0;
            wpos_q <= '0;
            for (int k = 0; k < int'(MAX_BYTES); k++) word_q[k] <= '0;
        end else if (busy && tick && !sclk && bit_cnt_q >= CMD_LEN) begin
            word_q[widx_q] <= {word_q[widx_q][WORD_BITS-2:0], sdi};
            if (wpos_q == POS_LAST) begin
                wpos_q <= '0;
                widx_q <= widx_q + 1'b1;
            end else begin
                wpos_q <= wpos_q + 1'b1;
            end
        end
    end

    for (genvar i = 0; i < int'(MAX_BYTES); i++) begin : g_pack
        assign words[i*WORD_BITS +: WORD_BITS] = word_q[i];
    end

    // R2: serial clock rests low whenever the device is deselected.
    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R2: data never moves while sclk is high (device samples on the rise).
    assert_sdo_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(sdo));

    // R3: a transfer ends only on a falling half of sclk, with select released.
    assert_end_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (cs_n && !sclk && !busy));
endmodule

// File: rtl/id_realign.sv
// Module: id_realign
// Purely combinational. Rebuilds true bytes from receive words that drift one
// bit per word: byte i = (word i >> i) | (low bits of word i-1 << (9 - i)).
// Assumes the first word carries one leading dummy bit.
module id_realign #(
    parameter int unsigned MAX_BYTES = 4,
    parameter int unsigned WORD_BITS = 9
) (
    input  logic [MAX_BYTES*WORD_BITS-1:0] words,
    output logic [MAX_BYTES*8-1:0]         bytes_out
);
    localparam int unsigned EXT_W = 2 * WORD_BITS;

    for (genvar i = 0; i < int'(MAX_BYTES); i++) begin : g_byte
        if (i < 2) begin : g_nocarry
            // Bytes 0 and 1 use no carry: a plain right shift of their own word.
            assign bytes_out[i*8 +: 8] =
                8'(({{WORD_BITS{1'b0}}, words[i*WORD_BITS +: WORD_BITS]}) >> i);
        end else begin : g_carry
            localparam logic [WORD_BITS-1:0] CMASK = WORD_BITS'((1 << (i - 1)) - 1);
            // Later bytes splice the low i-1 bits of the previous word on top.
            assign bytes_out[i*8 +: 8] = 8'(
                (EXT_W'(words[i*WORD_BITS +: WORD_BITS]) >> i) |
                (EXT_W'(words[(i-1)*WORD_BITS +: WORD_BITS] & CMASK) << (WORD_BITS - i)));
        end
    end
endmodule

// File: rtl/id_readback_realigner.sv
// Module: id_readback_realigner (top)
// Accepts an ID read request, checks the length and the no-receive strap,
// runs the serial exchange, realigns the bytes and compares them with the
// expected ID. Results are registered and held until the next accepted start.
// Assumes start is a single-cycle pulse; starts while busy are dropped.
module id_readback_realigner
    import id_rd_pkg::*;
#(
    parameter int unsigned HALF_DIV   = 2,
    parameter int unsigned LEN_W      = 3,
    parameter int unsigned NBYTES_MAX = MAX_BYTES,
    parameter int unsigned NWORD_BITS = WORD_BITS,
    parameter int unsigned NID_BYTES  = ID_BYTES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [LEN_W-1:0]        req_len,
    input  logic                    no_rx_line,
    input  logic                    sdi,
    output logic                    sclk,
    output logic                    cs_n,
    output logic                    sdo,
    output logic [NBYTES_MAX*8-1:0] id_bytes,
    output logic                    done,
    output logic                    valid,
    output logic                    id_ok,
    output logic                    len_err
);
    localparam int unsigned WVEC_W = NBYTES_MAX * NWORD_BITS;

    logic                    busy;
    logic                    tick;
    logic                    xfer_done;
    logic                    len_ok;
    logic                    accept;
    logic                    launch;
    logic [LEN_W-1:0]        len_q;
    logic [WVEC_W-1:0]       words;
    logic [NBYTES_MAX*8-1:0] raw_bytes;
    logic [NBYTES_MAX*8-1:0] masked_bytes;
    logic [NID_BYTES-1:0]    pos_match;

    // Request decode: only 1, 3 and 4 byte reads are supported.
    always_comb begin
        len_ok = (req_len == LEN_W'(1)) || (req_len == LEN_W'(3)) || (req_len == LEN_W'(4));
    end

    assign accept = start && !busy;
    assign launch = accept && !no_rx_line && len_ok;

    id_sclk_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    id_serial_engine #(
        .MAX_BYTES (NBYTES_MAX),
        .WORD_BITS (NWORD_BITS),
        .LEN_W     (LEN_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .nbytes    (req_len),
        .cmd       (CMD_GET_ID),
        .tick      (tick),
        .sdi       (sdi),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdo       (sdo),
        .busy      (busy),
        .xfer_done (xfer_done),
        .words     (words)
    );

    id_realign #(
        .MAX_BYTES (NBYTES_MAX),
        .WORD_BITS (NWORD_BITS)
    ) u_realign (
        .words     (words),
        .bytes_out (raw_bytes)
    );

    for (genvar i = 0; i < int'(NBYTES_MAX); i++) begin : g_mask
        // Positions beyond the requested length read as zero.
        assign masked_bytes[i*8 +: 8] =
            (LEN_W'(i) < len_q) ? raw_bytes[i*8 +: 8] : 8'h00;
    end

    for (genvar i = 0; i < int'(NID_BYTES); i++) begin : g_cmp
        // A position matches if it was not read or equals the expected byte.
        assign pos_match[i] = (LEN_W'(i) >= len_q) ||
                              (raw_bytes[i*8 +: 8] == expected_id(i));
    end

    // Result registers: cleared on an accepted start, set on skip, error or completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= '0;
            done     <= 1'b0;
            valid    <= 1'b0;
            id_ok    <= 1'b0;
            len_err  <= 1'b0;
            id_bytes <= '0;
        end else begin
            if (xfer_done) begin
                done     <= 1'b1;
                valid    <= 1'b1;
                id_ok    <= &pos_match;
                id_bytes <= masked_bytes;
            end
            if (accept) begin
                valid    <= 1'b0;
                id_bytes <= '0;
                len_q    <= req_len;
                done     <= no_rx_line || !len_ok;
                id_ok    <= no_rx_line;
                len_err  <= !no_rx_line && !len_ok;
            end
        end
    end

    // R6: a refused length raises the error and never selects the device.
    assert_bad_len_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !no_rx_line && !len_ok) |=> (done && len_err && cs_n && !valid));

    // R6: an error and valid data are never reported together.
    assert_err_excludes_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (!valid && !id_ok));

    // R8: the strap skips the transfer and reports a pass.
    assert_strap_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && no_rx_line) |=> (done && id_ok && !len_err && cs_n));

    // R9: results hold steady until a new start is presented.
    assert_hold_until_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(id_bytes) && $stable(id_ok) && $stable(valid)));
endmodule

// File: tb/tb_id_readback_realigner.sv
`timescale 1ns/1ps
module tb_id_readback_realigner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  req_len = 3'd0;
    logic        no_rx_line = 1'b0;
    logic        sdi = 1'b0;
    logic        sclk, cs_n, sdo, done, valid, id_ok, len_err;
    logic [31:0] id_bytes;

    int nchk = 0;
    int nerr = 0;

    logic [7:0] sbyte [5];
    logic       dbit;
    logic       strm [64];
    int         rc;     // sclk rising edges in the current request
    int         fc;     // sclk falling edges in the current request
    logic [8:0] cmd_cap;

    id_readback_realigner dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_len(req_len),
        .no_rx_line(no_rx_line), .sdi(sdi), .sclk(sclk), .cs_n(cs_n),
        .sdo(sdo), .id_bytes(id_bytes), .done(done), .valid(valid),
        .id_ok(id_ok), .len_err(len_err)
    );

    always #10 clk = ~clk;

    // Controller model: record the command, count edges, stream reply bits.
    always @(posedge sclk) begin
        if (rc < 9) cmd_cap = {cmd_cap[7:0], sdo};
        rc = rc + 1;
    end
    always @(negedge sclk) begin
        fc = fc + 1;
        if (fc >= 9) sdi = strm[fc - 9];
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_id(input int i);
        return (i == 2) ? 8'h52 : 8'h85;
    endfunction

    // Reply stream: one dummy bit, then the five bytes MSB first.
    task automatic build_stream();
        for (int k = 0; k < 64; k++) strm[k] = 1'b0;
        strm[0] = dbit;
        for (int k = 0; k < 5; k++)
            for (int j = 0; j < 8; j++) strm[1 + 8*k + j] = sbyte[k][7-j];
    endtask

    // Issue one request; optionally poke a second start mid-transfer.
    task automatic run_req(input int len, input bit strap, input int poke);
        int t;
        logic [31:0] eb;
        bit ok;
        bit good;
        build_stream();
        rc = 0; fc = 0; cmd_cap = '0; sdi = 1'b0;
        @(negedge clk);
        start = 1'b1; req_len = 3'(len); no_rx_line = strap;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 4000) begin
            @(negedge clk);
            t++;
            if (poke != 0 && t == poke) begin
                start = 1'b1; req_len = 3'd1; no_rx_line = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0; no_rx_line = 1'b0;
        check("R9 request completes", 64'(done), 64'd1);
        good = (len == 1 || len == 3 || len == 4);
        if (strap) begin
            check("R8 strap id_ok", 64'(id_ok), 64'd1);
            check("R8 strap valid", 64'(valid), 64'd0);
            check("R8 strap len_err", 64'(len_err), 64'd0);
            check("R8 strap no clocks", 64'(rc), 64'd0);
        end else if (!good) begin
            check("R6 len_err", 64'(len_err), 64'd1);
            check("R6 valid", 64'(valid), 64'd0);
            check("R6 id_ok", 64'(id_ok), 64'd0);
            check("R6 no clocks", 64'(rc), 64'd0);
        end else begin
            eb = '0;
            ok = 1'b1;
            for (int i = 0; i < len; i++) eb[i*8 +: 8] = sbyte[i];
            for (int i = 0; i < len && i < 3; i++) if (sbyte[i] != exp_id(i)) ok = 1'b0;
            check("R2 command word", 64'(cmd_cap), 64'h004);
            check("R3 sclk edge count", 64'(rc), 64'(9 * (len + 1)));
            check("R4 bytes 0-1", 64'(id_bytes[15:0]), 64'(eb[15:0]));
            check("R5 bytes 2-3", 64'(id_bytes[31:16]), 64'(eb[31:16]));
            check("R10 full layout", 64'(id_bytes), 64'(eb));
            check("R7 id_ok", 64'(id_ok), 64'(ok));
            check("R7 valid", 64'(valid), 64'd1);
            check("R2 cs_n released", 64'(cs_n), 64'd1);
        end
    endtask

    task automatic set_id(input logic [7:0] b3, input logic [7:0] b4);
        sbyte[0] = 8'h85; sbyte[1] = 8'h85; sbyte[2] = 8'h52;
        sbyte[3] = b3;    sbyte[4] = b4;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] held;
        rc = 0; fc = 0; cmd_cap = '0; dbit = 1'b0;
        set_id(8'h00, 8'h00);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 sclk", 64'(sclk), 64'd0);
        check("R1 cs_n", 64'(cs_n), 64'd1);
        check("R1 sdo", 64'(sdo), 64'd0);
        check("R1 flags", 64'({done, valid, id_ok, len_err}), 64'd0);
        check("R1 id_bytes", 64'(id_bytes), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Matching ID behind both dummy-bit values, all legal lengths.
        for (int d = 0; d < 2; d++) begin
            dbit = d[0];
            set_id(8'hA7, 8'h3C);
            run_req(1, 1'b0, 0);
            run_req(3, 1'b0, 0);
            run_req(4, 1'b0, 0);
        end

        // Single-bit corruption in each ID position (R7), lengths 3 and 4.
        for (int p = 0; p < 3; p++)
            for (int b = 0; b < 8; b++) begin
                set_id(8'h5A, 8'hC3);
                sbyte[p] = sbyte[p] ^ (8'h01 << b);
                dbit = b[0];
                run_req(3, 1'b0, 0);
                run_req(4, 1'b0, 0);
                if (p == 0) run_req(1, 1'b0, 0);
            end

        // Corruption beyond the first byte with a one-byte read still passes (R7).
        set_id(8'h11, 8'h22);
        sbyte[2] = 8'hFF;
        run_req(1, 1'b0, 0);

        // Arithmetic byte patterns exercising the carry splice (R4, R5).
        for (int s = 0; s < 12; s++) begin
            for (int k = 0; k < 5; k++) sbyte[k] = 8'((s * 37 + k * 91 + 13) & 8'hFF);
            dbit = s[1];
            run_req(4, 1'b0, 0);
            run_req(3, 1'b0, 0);
        end
        // Walking ones and all-ones bytes.
        for (int k = 0; k < 5; k++) sbyte[k] = 8'h80 >> k;
        dbit = 1'b1;
        run_req(4, 1'b0, 0);
        for (int k = 0; k < 5; k++) sbyte[k] = 8'hFF;
        run_req(4, 1'b0, 0);

        // Unsupported lengths (R6) and strap with every length (R8).
        for (int l = 0; l < 8; l++)
            if (l != 1 && l != 3 && l != 4) run_req(l, 1'b0, 0);
        for (int l = 0; l < 8; l++) run_req(l, 1'b1, 0);

        // Start while busy is ignored (R9).
        dbit = 1'b0;
        set_id(8'h9E, 8'h01);
        run_req(4, 1'b0, 40);

        // Outputs hold with no new start (R9).
        held = id_bytes;
        repeat (30) @(negedge clk);
        check("R9 bytes held", 64'(id_bytes), 64'(held));
        check("R9 flags held", 64'({done, valid, id_ok, len_err}), 64'b1110);
        check("R9 bus idle", 64'({cs_n, sclk}), 64'b10);

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule